// File: doc/BRIEF.md
# Ripple-Chained Bit-Slice Integer ALU

This block is a purely combinational integer arithmetic and logic unit built from a row of identical one-bit cells. Each cell holds an AND gate, an OR gate, a full adder whose b input passes through a conditional inverter, and a four-way output selector. The cells are chained through their carries, so the carry ripples from the lowest bit to the highest. A three-bit control word picks the operation. Its top bit is a single negate line that inverts b in every cell and also supplies the carry into bit 0, which turns the adder into a subtractor. Its lower two bits choose what each cell drives onto its result bit.

Set-less-than works by feeding the raw sign bit of the top cell's adder back into the spare selector input of bit 0. The spare selector inputs of all other cells are tied low. An equality test uses subtraction and reads the zero flag. The block is meant to sit in the execute stage of a simple integer datapath, with its outputs valid in the same cycle as its inputs.

Top module: `alu_ripple`

## Requirements
- R1: Control 3'b000 (AND) drives result = a & b.
- R2: Control 3'b001 (OR) drives result = a | b.
- R3: Control 3'b010 (ADD) drives result = (a + b) mod 2^32, and carry_out is bit 32 of the 33-bit sum.
- R4: Control 3'b110 (SUB) drives result = a + ~b + 1 mod 2^32, and carry_out is bit 32 of that 33-bit sum, which is 1 when no borrow occurs.
- R5: For ADD, SUB and SLT, overflow is 1 exactly when the signed result of the adder does not fit in 32 bits. For ADD this means both operands have the same sign and the sum sign differs from it. For SUB and SLT it means the operand signs differ and the difference sign differs from a's sign.
- R6: Under every control code, zero is 1 exactly when all 32 result bits are 0.
- R7: Control 3'b111 (SLT) drives result bits 31..1 to 0 and result bit 0 to bit 31 of a + ~b + 1, with no overflow correction. When the difference does not overflow, bit 0 equals the signed comparison a < b. When it does overflow, bit 0 is still the raw sign, so a = 32'h8000_0000, b = 1 gives 0, and a = 32'h7FFF_FFFF, b = 32'hFFFF_FFFF gives 1.
- R8: Equality test: under SUB, zero is 1 if and only if a == b.
- R9: The unused control codes 3'b011, 3'b100 and 3'b101 drive result = 0, so zero reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand; inverted inside every cell when the negate bit is set |
| ctrl | input | 3 | Bit 2 is the negate line; bits 1..0 select AND, OR, adder sum or less input |
| result | output | 32 | Operation result |
| zero | output | 1 | High when every result bit is low |
| overflow | output | 1 | Carry into bit 31 XOR carry out of bit 31 |
| carry_out | output | 1 | Carry out of the top cell |

## Verification
The operand patterns include small positive and negative values, operands that carry across all 32 bits, such as all-ones plus one, and the two signed extremes. Together they separate a correct carry chain from one that drops or misroutes a carry, and separate a true overflow from a plain unsigned carry. The subtraction and set-less-than cases pair equal operands, operands that differ only in bit 31, and differences that overflow in each direction. These show that the negate line feeds both the inverter and the carry-in, that the fed-back bit is the raw adder sign, and that the equality test depends on every bit. The unused control codes are applied with non-zero operands, so a missing result mask shows up as a non-zero result.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned ALU_W  = 32;
    localparam int unsigned CTRL_W = 3;

    typedef enum logic [1:0] {
        SEL_AND  = 2'd0,
        SEL_OR   = 2'd1,
        SEL_SUM  = 2'd2,
        SEL_LESS = 2'd3
    } slice_sel_e;

    typedef struct packed {
        logic       negate;
        slice_sel_e sel;
        logic       valid;
    } alu_cmd_t;

    localparam logic [CTRL_W-1:0] CTRL_AND = 3'b000;
    localparam logic [CTRL_W-1:0] CTRL_OR  = 3'b001;
    localparam logic [CTRL_W-1:0] CTRL_ADD = 3'b010;
    localparam logic [CTRL_W-1:0] CTRL_SUB = 3'b110;
    localparam logic [CTRL_W-1:0] CTRL_SLT = 3'b111;

endpackage

// File: rtl/alu_ctrl_decode.sv
module alu_ctrl_decode
    import alu_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    output alu_cmd_t          cmd
);

    alu_cmd_t cmd_d;

    always_comb begin
        cmd_d.negate = ctrl[CTRL_W-1];
        cmd_d.sel    = slice_sel_e'(ctrl[1:0]);
        unique case (ctrl)
            CTRL_AND, CTRL_OR, CTRL_ADD, CTRL_SUB, CTRL_SLT: cmd_d.valid = 1'b1;
            default:                                        cmd_d.valid = 1'b0;
        endcase
    end

    assign cmd = cmd_d;

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       negate_i,
    input  logic       cin_i,
    input  logic       less_i,
    input  slice_sel_e sel_i,
    output logic       res_o,
    output logic       cout_o,
    output logic       set_o
);

    logic b_eff_d;
    logic sum_d;
    logic carry_d;
    logic res_d;

    assign b_eff_d = b_i ^ negate_i;
    assign sum_d   = a_i ^ b_eff_d ^ cin_i;
    assign carry_d = (a_i & b_eff_d) | (a_i & cin_i) | (b_eff_d & cin_i);

    always_comb begin
        unique case (sel_i)
            SEL_AND:  res_d = a_i & b_eff_d;
            SEL_OR:   res_d = a_i | b_eff_d;
            SEL_SUM:  res_d = sum_d;
            SEL_LESS: res_d = less_i;
            default:  res_d = 1'b0;
        endcase
    end

    assign res_o  = res_d;
    assign cout_o = carry_d;
    assign set_o  = sum_d;

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] value_i,
    output logic         zero_o
);

    assign zero_o = ~|value_i;

endmodule

// File: rtl/alu_ripple.sv
module alu_ripple
    import alu_pkg::*;
#(
    parameter int unsigned W = ALU_W
) (
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [W-1:0]      result,
    output logic              zero,
    output logic              overflow,
    output logic              carry_out
);

    localparam int unsigned MSB = W - 1;

    alu_cmd_t       cmd;
    logic [W-1:0]   raw_res_d;
    logic [W-1:0]   result_d;

    alu_ctrl_decode u_decode (
        .ctrl (ctrl),
        .cmd  (cmd)
    );

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic cin_w;
        logic cout_w;
        logic less_w;
        logic res_w;
        logic set_w;

        if (i == 0) begin : g_first
            assign cin_w  = cmd.negate;
            assign less_w = g_bit[MSB].set_w;
        end else begin : g_rest
            assign cin_w  = g_bit[i-1].cout_w;
            assign less_w = 1'b0;
        end

        alu_bit_slice u_slice (
            .a_i      (a[i]),
            .b_i      (b[i]),
            .negate_i (cmd.negate),
            .cin_i    (cin_w),
            .less_i   (less_w),
            .sel_i    (cmd.sel),
            .res_o    (res_w),
            .cout_o   (cout_w),
            .set_o    (set_w)
        );

        assign raw_res_d[i] = res_w;
    end

    assign result_d  = cmd.valid ? raw_res_d : '0;
    assign result    = result_d;
    assign carry_out = g_bit[MSB].cout_w;
    assign overflow  = g_bit[MSB].cin_w ^ g_bit[MSB].cout_w;

    alu_zero_detect #(.W(W)) u_zero (
        .value_i (result_d),
        .zero_o  (zero)
    );

    always_comb begin
        if (ctrl == CTRL_AND) begin
            assert_and_R1: assert (result == (a & b))
                else $error("R1 AND result mismatch");
        end
        if (ctrl == CTRL_OR) begin
            assert_or_R2: assert (result == (a | b))
                else $error("R2 OR result mismatch");
        end
        if (ctrl == CTRL_ADD) begin
            assert_add_R3: assert ({carry_out, result} == ({1'b0, a} + {1'b0, b}))
                else $error("R3 ADD sum mismatch");
            assert_add_ovf_R5: assert (overflow ==
                    ((a[MSB] == b[MSB]) && (result[MSB] != a[MSB])))
                else $error("R5 ADD overflow mismatch");
        end
        if (ctrl == CTRL_SUB) begin
            assert_sub_R4: assert ({carry_out, result} ==
                    ({1'b0, a} + {1'b0, ~b} + (W+1)'(1)))
                else $error("R4 SUB difference mismatch");
            assert_sub_ovf_R5: assert (overflow ==
                    ((a[MSB] != b[MSB]) && (result[MSB] != a[MSB])))
                else $error("R5 SUB overflow mismatch");
            assert_equal_R8: assert (zero == (a == b))
                else $error("R8 equality mismatch");
        end
        if (ctrl == CTRL_SLT) begin
            assert_slt_upper_R7: assert (result[MSB:1] == '0)
                else $error("R7 SLT upper bits not clear");
            if (!overflow) begin
                assert_slt_signed_R7: assert (result[0] == ($signed(a) < $signed(b)))
                    else $error("R7 SLT compare mismatch");
            end
        end
    end

endmodule

// File: tb/test_alu_ripple.sv
`timescale 1ns/1ps
module test_alu_ripple;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [2:0]  ctrl = 3'b010;
    logic [31:0] result;
    logic        zero;
    logic        overflow;
    logic        carry_out;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          done     = 1'b0;

    always #2.5 clk = ~clk;

    alu_ripple i_alu_ripple (
        .a         (a),
        .b         (b),
        .ctrl      (ctrl),
        .result    (result),
        .zero      (zero),
        .overflow  (overflow),
        .carry_out (carry_out)
    );

    localparam int NV = 22;
    localparam logic [66:0] VEC [NV] = '{
        {3'b000, 32'hF0F0_1234, 32'h0FF0_FF00},
        {3'b000, 32'hFFFF_FFFF, 32'h0000_0000},
        {3'b001, 32'hF0F0_0000, 32'h0F0F_0001},
        {3'b001, 32'h0000_0000, 32'h0000_0000},
        {3'b010, 32'h0000_0003, 32'h0000_0002},
        {3'b010, 32'h0000_0007, 32'hFFFF_FFFA},
        {3'b010, 32'h7FFF_FFFF, 32'h0000_0001},
        {3'b010, 32'h8000_0000, 32'h8000_0000},
        {3'b010, 32'hFFFF_FFFF, 32'h0000_0001},
        {3'b110, 32'h0000_0007, 32'h0000_0003},
        {3'b110, 32'h0000_0003, 32'h0000_0005},
        {3'b110, 32'h8000_0000, 32'h0000_0001},
        {3'b110, 32'h0000_0005, 32'h0000_0005},
        {3'b110, 32'h1234_5678, 32'h1234_5679},
        {3'b111, 32'hFFFF_FFFC, 32'h0000_0003},
        {3'b111, 32'h0000_0003, 32'hFFFF_FFFC},
        {3'b111, 32'h0000_0005, 32'h0000_0005},
        {3'b111, 32'h8000_0000, 32'h0000_0001},
        {3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF},
        {3'b011, 32'hDEAD_BEEF, 32'h1234_5678},
        {3'b100, 32'hFFFF_FFFF, 32'h0000_0000},
        {3'b101, 32'hA5A5_A5A5, 32'h5A5A_5A5A}
    };

    function automatic logic [34:0] model(input logic [2:0] c,
                                          input logic [31:0] x,
                                          input logic [31:0] y);
        logic [32:0] s;
        logic [31:0] r;
        logic        ov;
        s  = {1'b0, x} + {1'b0, y};
        ov = 1'b0;
        r  = '0;
        case (c)
            3'b000: r = x & y;
            3'b001: r = x | y;
            3'b010: begin
                r  = s[31:0];
                ov = (x[31] == y[31]) && (r[31] != x[31]);
            end
            3'b110, 3'b111: begin
                s  = {1'b0, x} + {1'b0, ~y} + 33'd1;
                ov = (x[31] != y[31]) && (s[31] != x[31]);
                r  = (c == 3'b110) ? s[31:0] : {31'b0, s[31]};
            end
            default: r = '0;
        endcase
        return {r, (r == 32'd0), ov, s[32]};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (ctrl=%b a=%h b=%h)",
                     req, what, got, exp, ctrl, a, b);
        end
    endtask

    task automatic apply(input logic [2:0] c, input logic [31:0] x, input logic [31:0] y);
        @(negedge clk);
        ctrl = c;
        a    = x;
        b    = y;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b110:  return "R4";
            3'b111:  return "R7";
            default: return "R9";
        endcase
    endfunction

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [34:0] e;
        repeat (3) @(posedge clk);
        #1;
        // reset state: all-zero operands under ADD
        chk("R6", "reset result", result, 32'd0);
        chk("R6", "reset zero", {31'b0, zero}, 32'd1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][66:64], VEC[i][63:32], VEC[i][31:0]);
            e = model(ctrl, a, b);
            chk(req_of(ctrl), "result", result, e[34:3]);
            chk("R6", "zero", {31'b0, zero}, {31'b0, e[2]});
            if (ctrl == 3'b010 || ctrl == 3'b110 || ctrl == 3'b111) begin
                chk("R5", "overflow", {31'b0, overflow}, {31'b0, e[1]});
                chk((ctrl == 3'b010) ? "R3" : "R4", "carry_out",
                    {31'b0, carry_out}, {31'b0, e[0]});
            end
        end

        // R7 against signed comparison where no overflow occurs
        for (int k = -3; k <= 3; k++) begin
            for (int m = -3; m <= 3; m++) begin
                apply(3'b111, 32'(k * 1000), 32'(m * 777));
                chk("R7", "slt signed", result, {31'b0, (k * 1000) < (m * 777)});
            end
        end

        // R7 overflow cases keep the raw sign
        apply(3'b111, 32'h8000_0000, 32'h0000_0001);
        chk("R7", "slt ovf min-1", result, 32'd0);
        chk("R5", "slt ovf flag", {31'b0, overflow}, 32'd1);
        apply(3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        chk("R7", "slt ovf max-(-1)", result, 32'd1);

        // R8 equality test
        apply(3'b110, 32'hCAFE_F00D, 32'hCAFE_F00D);
        chk("R8", "equal", {31'b0, zero}, 32'd1);
        apply(3'b110, 32'hCAFE_F00D, 32'h4AFE_F00D);
        chk("R8", "differ in msb", {31'b0, zero}, 32'd0);
        apply(3'b110, 32'h0000_0000, 32'h0000_0001);
        chk("R8", "differ in lsb", {31'b0, zero}, 32'd0);

        // R9 unused codes with all-ones operands
        for (int c = 3; c <= 5; c++) begin
            apply(3'(c), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
            chk("R9", "unused result", result, 32'd0);
            chk("R6", "unused zero", {31'b0, zero}, 32'd1);
        end

        finish_run();
    end

endmodule